// File: doc/BRIEF.md
# CAN Frame Destuffer and Field Parser

This block sits behind a bit sampler on a CAN receive path. Each sampled bus level arrives with a one-cycle strobe. The block first strips stuff bits from the raw stream. It then follows the frame bit by bit and steers each bit into the right field register. The layout used from bit 14 onward depends on the identifier-extension bit, so the same logic handles both base-format and extended-format frames, data or remote.

When the last end-of-frame bit arrives, the block raises a one-cycle done strobe so that the sampler can go back to hunting for a start bit. In the same cycle it raises a valid strobe if the frame broke no format rule. The parsed fields stay on the outputs until the next start bit is accepted. A six-bit violation vector records every fixed-form rule that the frame broke. CRC computation, error and overload frames, and transmission are not handled here.

Top module: `can_frame_rx`

## Requirements
- R1: Once five consecutive raw bits share a level, a following raw bit of the opposite level is a stuff bit. It does not advance the frame position, but it counts as the first bit of a new run for later stuff detection. Bit positions below are destuffed positions.
- R2: Stuff removal applies only up to the last CRC bit. From the CRC delimiter onward, every raw bit is a frame bit, even after five equal bits.
- R3: Base format (bit 13 = 0): bits 1..11 are `baseId`, MSB first; bit 12 is the remote flag; bits 15..18 are `dlc`, MSB first; `extId` reads 0; `fullId` is `baseId` zero-extended.
- R4: Extended format (bit 13 = 1): bits 14..31 are `extId`, MSB first; bit 32 is the remote flag; bits 35..38 are `dlc`; `fullId` equals `{baseId, extId}`; `isExtended` reads 1.
- R5: Data byte i (0 first, MSB first on the bus) appears at `dataOut[63-8i -: 8]`. Bytes that were not received read 0. A remote frame (remote bit recessive) has no data field, whatever its `dlc`.
- R6: A `dlc` above 8 sets `violations[2]`, the raw code still appears on `dlc`, and exactly 8 data bytes are taken.
- R7: The 15 bits after the data field appear on `crcField`, MSB first. `ackSeen` is 1 when the acknowledge slot is dominant (0) and 0 when it is recessive.
- R8: The violation bits are: [0] start bit recessive, [1] `baseId[10:4]` all ones, [3] CRC delimiter dominant, [4] acknowledge delimiter dominant, [5] any of the seven end-of-frame bits dominant. All bits clear when the next start bit is accepted.
- R9: `frameDone` is high for exactly one cycle, in the cycle after the seventh end-of-frame bit is accepted, and never earlier in a frame. The next accepted bit is taken as a start bit.
- R10: `frameValid` pulses together with `frameDone` exactly when all violation bits are 0.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | One-cycle strobe: a sampled bus bit is present |
| bitIn | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| frameDone | output | 1 | End-of-frame pulse to the sampler |
| frameValid | output | 1 | Pulse: frame ended without format violations |
| baseId | output | 11 | Base identifier |
| extId | output | 18 | Identifier extension |
| fullId | output | 29 | Combined identifier |
| isExtended | output | 1 | Frame used the extended format |
| isRemote | output | 1 | Frame was a remote request |
| dlc | output | 4 | Received data-length code |
| dataOut | output | 64 | Data bytes, byte 0 in the top 8 bits |
| crcField | output | 15 | Received CRC sequence |
| ackSeen | output | 1 | Acknowledge slot was dominant |
| violations | output | 6 | Format-rule violation flags |

## Verification
A frame position that has slipped by even one bit, for example because a stuff bit was missed or dropped wrongly, shows up at the end of the frame. `frameDone` then arrives early, arrives late, or never arrives. The shifted fields also land on the identifier, CRC and delimiter outputs, where the delimiter and end-of-frame flags usually trip. A wrong field boundary after the IDE or DLC decision shows up as scrambled `dataOut` bytes or a CRC value that is one bit off, visible in the done cycle of that same frame. The stimulus places runs of five equal bits right at the CRC/delimiter boundary, and it includes remote frames that carry a non-zero `dlc`.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W       = 11;
  localparam int EXT_W      = 18;
  localparam int FULL_W     = ID_W + EXT_W;
  localparam int DLC_W      = 4;
  localparam int MAX_BYTES  = 8;
  localparam int DATA_W     = MAX_BYTES * 8;
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int CRC_W      = 15;
  localparam int RUN_LIMIT  = 5;
  localparam int RUN_W      = $clog2(RUN_LIMIT + 1);
  localparam int POS_W      = 8;
  localparam int VIOL_W     = 6;
  localparam int STD_DLC_END = 18;
  localparam int EXT_DLC_END = 38;
  localparam int EOF_LEN    = 7;
  // positions after the last data bit
  localparam int T_CRC_LAST = CRC_W;
  localparam int T_CRC_DEL  = CRC_W + 1;
  localparam int T_ACK      = CRC_W + 2;
  localparam int T_ACK_DEL  = CRC_W + 3;
  localparam int T_EOF_FIRST = CRC_W + 4;
  localparam int T_EOF_LAST = T_EOF_FIRST + EOF_LEN - 1;
  // violation bit positions
  localparam int V_SOF  = 0;
  localparam int V_ID   = 1;
  localparam int V_DLC  = 2;
  localparam int V_CRCD = 3;
  localparam int V_ACKD = 4;
  localparam int V_EOF  = 5;

  typedef struct packed {
    logic             frameStart;
    logic             idShift;
    logic             bit12Cap;
    logic             ideCap;
    logic             extShift;
    logic             rtrCap;
    logic             dlcShift;
    logic             dlcLast;
    logic             dataShift;
    logic [IDX_W-1:0] dataIdx;
    logic             crcShift;
    logic             crcDelimChk;
    logic             ackCap;
    logic             ackDelimChk;
    logic             eofChk;
    logic             lastBit;
  } strobe_t;
endpackage

// File: rtl/can_rx_destuff.sv
module can_rx_destuff
  import can_rx_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic bitIn,
  input  logic stuffEn,
  input  logic clearHist,
  output logic frameBitValid,
  output logic frameBit
);
  logic [RUN_W-1:0] runLen;
  logic             lastRaw;
  logic             isStuff;

  assign isStuff       = bitValid && stuffEn && (runLen == RUN_W'(RUN_LIMIT)) && (bitIn != lastRaw);
  assign frameBitValid = bitValid && !isStuff;
  assign frameBit      = bitIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen  <= '0;
      lastRaw <= 1'b1;
    end else if (clearHist) begin
      runLen  <= '0;
      lastRaw <= 1'b1;
    end else if (bitValid) begin
      if (runLen != '0 && bitIn == lastRaw)
        runLen <= (runLen == RUN_W'(RUN_LIMIT)) ? runLen : runLen + 1'b1;
      else
        runLen <= RUN_W'(1);
      lastRaw <= bitIn;
    end
  end

  // R2: a bit is only ever swallowed while stuff removal is enabled
  a_r2_drop_only_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !frameBitValid) |-> stuffEn);
  // R1: a swallowed bit always breaks a full-length run
  a_r1_drop_after_run: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !frameBitValid) |-> (runLen == RUN_W'(RUN_LIMIT)));
endmodule

// File: rtl/can_rx_ctrl.sv
module can_rx_ctrl
  import can_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameBitValid,
  input  logic       frameBit,
  input  logic       isExt,
  input  logic       isRemote,
  input  logic [2:0] dlcLow,
  output strobe_t    strb,
  output logic       stuffEn,
  output logic       frameDone
);
  localparam logic [POS_W-1:0] STD_END = POS_W'(STD_DLC_END);
  localparam logic [POS_W-1:0] EXT_END = POS_W'(EXT_DLC_END);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] lastData;
  logic             dlcKnown;
  logic [POS_W-1:0] dlcEnd;
  logic [POS_W-1:0] tail;
  logic             inTail;
  logic [DLC_W-1:0] dlcNext;
  logic [DLC_W-1:0] nBytes;
  logic [POS_W-1:0] dataBits;

  always_comb begin
    dlcEnd   = isExt ? EXT_END : STD_END;
    tail     = pos - lastData;
    inTail   = dlcKnown && (pos > lastData);
    stuffEn  = !(inTail && tail >= POS_W'(T_CRC_DEL));
    dlcNext  = {dlcLow, frameBit};
    nBytes   = (dlcNext > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlcNext;
    dataBits = isRemote ? '0 : {nBytes, 3'b000};
  end

  always_comb begin
    strb = '0;
    if (frameBitValid) begin
      strb.frameStart  = (pos == '0);
      strb.idShift     = (pos >= POS_W'(1)) && (pos <= POS_W'(ID_W));
      strb.bit12Cap    = (pos == POS_W'(12));
      strb.ideCap      = (pos == POS_W'(13));
      strb.extShift    = isExt && (pos >= POS_W'(14)) && (pos <= POS_W'(31));
      strb.rtrCap      = isExt && (pos == POS_W'(32));
      strb.dlcShift    = (pos >= POS_W'(14)) && (pos >= dlcEnd - POS_W'(3)) && (pos <= dlcEnd);
      strb.dlcLast     = (pos >= POS_W'(14)) && (pos == dlcEnd);
      strb.dataShift   = dlcKnown && !inTail;
      strb.crcShift    = inTail && (tail <= POS_W'(T_CRC_LAST));
      strb.crcDelimChk = inTail && (tail == POS_W'(T_CRC_DEL));
      strb.ackCap      = inTail && (tail == POS_W'(T_ACK));
      strb.ackDelimChk = inTail && (tail == POS_W'(T_ACK_DEL));
      strb.eofChk      = inTail && (tail >= POS_W'(T_EOF_FIRST)) && (tail <= POS_W'(T_EOF_LAST));
      strb.lastBit     = inTail && (tail == POS_W'(T_EOF_LAST));
    end
    strb.dataIdx = IDX_W'(pos - dlcEnd - POS_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos       <= '0;
      lastData  <= '1;
      dlcKnown  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= frameBitValid && strb.lastBit;
      if (frameBitValid) begin
        if (strb.lastBit) begin
          pos      <= '0;
          lastData <= '1;
          dlcKnown <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
          if (strb.dlcLast) begin
            dlcKnown <= 1'b1;
            lastData <= dlcEnd + dataBits;
          end
        end
      end
    end
  end

  // R1: stuff bits never move the frame position
  a_r1_pos_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameBitValid |=> $stable(pos));
  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  // R6: the data field never exceeds eight bytes
  a_r6_data_bound: assert property (@(posedge clk) disable iff (!rstN)
    dlcKnown |-> (lastData <= dlcEnd + POS_W'(DATA_W)));
  // R9: after done the position is back at the start bit
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (pos == '0));
endmodule

// File: rtl/can_rx_data.sv
module can_rx_data
  import can_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              frameBit,
  output logic [ID_W-1:0]   baseId,
  output logic [EXT_W-1:0]  extId,
  output logic [FULL_W-1:0] fullId,
  output logic              isExtended,
  output logic              isRemote,
  output logic [DLC_W-1:0]  dlc,
  output logic [DATA_W-1:0] dataOut,
  output logic [CRC_W-1:0]  crcField,
  output logic              ackSeen,
  output logic [VIOL_W-1:0] violations,
  output logic              frameValid
);
  logic             bit12;
  logic             rtrExt;
  logic [IDX_W-1:0] bitSel;

  assign isRemote = isExtended ? rtrExt : bit12;
  assign fullId   = isExtended ? {baseId, extId} : {{EXT_W{1'b0}}, baseId};
  assign bitSel   = IDX_W'(DATA_W - 1) - strb.dataIdx;

  always_ff @(posedge clk) begin
    if (!rstN || strb.frameStart) begin
      baseId     <= '0;
      extId      <= '0;
      isExtended <= 1'b0;
      bit12      <= 1'b0;
      rtrExt     <= 1'b0;
      dlc        <= '0;
      dataOut    <= '0;
      crcField   <= '0;
      ackSeen    <= 1'b0;
      violations <= '0;
      frameValid <= 1'b0;
      if (rstN) violations[V_SOF] <= frameBit;
    end else begin
      frameValid <= strb.lastBit && (violations == '0) && frameBit;
      if (strb.idShift)  baseId <= {baseId[ID_W-2:0], frameBit};
      if (strb.bit12Cap) begin
        bit12 <= frameBit;
        violations[V_ID] <= &baseId[ID_W-1:4];
      end
      if (strb.ideCap)   isExtended <= frameBit;
      if (strb.extShift) extId <= {extId[EXT_W-2:0], frameBit};
      if (strb.rtrCap)   rtrExt <= frameBit;
      if (strb.dlcShift) dlc <= {dlc[DLC_W-2:0], frameBit};
      if (strb.dlcLast)  violations[V_DLC] <= ({dlc[DLC_W-2:0], frameBit} > DLC_W'(MAX_BYTES));
      if (strb.dataShift) dataOut[bitSel] <= frameBit;
      if (strb.crcShift) crcField <= {crcField[CRC_W-2:0], frameBit};
      if (strb.crcDelimChk) violations[V_CRCD] <= !frameBit;
      if (strb.ackCap)   ackSeen <= !frameBit;
      if (strb.ackDelimChk) violations[V_ACKD] <= !frameBit;
      if (strb.eofChk && !frameBit) violations[V_EOF] <= 1'b1;
    end
  end

  // R10: a valid pulse never coexists with a recorded violation
  a_r10_valid_clean: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (violations == '0));
  // R4: base-format frames leave the extension field empty
  a_r4_ext_empty: assert property (@(posedge clk) disable iff (!rstN)
    !isExtended |-> (extId == '0));
endmodule

// File: rtl/can_frame_rx.sv
module can_frame_rx
  import can_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  output logic              frameDone,
  output logic              frameValid,
  output logic [ID_W-1:0]   baseId,
  output logic [EXT_W-1:0]  extId,
  output logic [FULL_W-1:0] fullId,
  output logic              isExtended,
  output logic              isRemote,
  output logic [DLC_W-1:0]  dlc,
  output logic [DATA_W-1:0] dataOut,
  output logic [CRC_W-1:0]  crcField,
  output logic              ackSeen,
  output logic [VIOL_W-1:0] violations
);
  strobe_t strb;
  logic    stuffEn;
  logic    frameBitValid;
  logic    frameBit;

  can_rx_destuff u_destuff (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .stuffEn(stuffEn), .clearHist(strb.lastBit),
    .frameBitValid(frameBitValid), .frameBit(frameBit)
  );

  can_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameBitValid(frameBitValid), .frameBit(frameBit),
    .isExt(isExtended), .isRemote(isRemote), .dlcLow(dlc[DLC_W-2:0]),
    .strb(strb), .stuffEn(stuffEn), .frameDone(frameDone)
  );

  can_rx_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .frameBit(frameBit),
    .baseId(baseId), .extId(extId), .fullId(fullId), .isExtended(isExtended),
    .isRemote(isRemote), .dlc(dlc), .dataOut(dataOut), .crcField(crcField),
    .ackSeen(ackSeen), .violations(violations), .frameValid(frameValid)
  );

  // R10: the valid pulse only comes with the done pulse
  a_r10_valid_with_done: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> frameDone);
endmodule

// File: tb/can_frame_rx_bench.sv
module can_frame_rx_bench;
  import can_rx_pkg::*;

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [10:0] id;
    logic [17:0] eid;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [14:0] crc;
    logic        ack;
    logic [5:0]  corrupt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 11'h123, 18'h0,     4'd2,  64'hABCD_0000_0000_0000, 15'h1234, 1'b0, 6'b000000},
    '{1'b0, 1'b0, 11'h000, 18'h0,     4'd8,  64'h0,                   15'h0000, 1'b0, 6'b000000},
    '{1'b1, 1'b0, 11'h555, 18'h3FFFF, 4'd4,  64'h8142_7E3C_0000_0000, 15'h7FE0, 1'b1, 6'b000000},
    '{1'b0, 1'b1, 11'h0F0, 18'h0,     4'd3,  64'h1122_3344_5566_7788, 15'h2A55, 1'b0, 6'b000000},
    '{1'b0, 1'b0, 11'h2C1, 18'h0,     4'd15, 64'hFFEE_DDCC_BBAA_9988, 15'h0F0F, 1'b0, 6'b000000},
    '{1'b0, 1'b0, 11'h7F5, 18'h0,     4'd1,  64'h5A00_0000_0000_0000, 15'h1111, 1'b0, 6'b000001},
    '{1'b1, 1'b1, 11'h3A0, 18'h15A5A, 4'd6,  64'h0,                   15'h4321, 1'b0, 6'b111000},
    '{1'b0, 1'b0, 11'h061, 18'h0,     4'd1,  64'hC300_0000_0000_0000, 15'h0777, 1'b0, 6'b100000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic bitIn = 1'b1;
  logic frameDone, frameValid, isExtended, isRemote, ackSeen;
  logic [10:0] baseId;
  logic [17:0] extId;
  logic [28:0] fullId;
  logic [3:0]  dlc;
  logic [63:0] dataOut;
  logic [14:0] crcField;
  logic [5:0]  violations;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int doneCount;
  bit validSeen;
  bit doneOnLast;
  int stuffCount;
  logic fb [0:255];

  always #10 clk = ~clk;

  can_frame_rx u_can_frame_rx (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .frameDone(frameDone), .frameValid(frameValid), .baseId(baseId), .extId(extId),
    .fullId(fullId), .isExtended(isExtended), .isRemote(isRemote), .dlc(dlc),
    .dataOut(dataOut), .crcField(crcField), .ackSeen(ackSeen), .violations(violations)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input bit isLast);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    if (frameDone) begin
      doneCount++;
      if (isLast) doneOnLast = 1;
    end
    if (frameValid) validSeen = 1;
  endtask

  task automatic sendFrame(input vec_t v);
    int nb, dEnd, last, len, run;
    logic prev;
    nb   = v.rtr ? 0 : ((v.dlc > 4'd8) ? 8 : int'(v.dlc));
    dEnd = v.ext ? 38 : 18;
    last = dEnd + 8 * nb;
    len  = 0;
    fb[len++] = v.corrupt[0];
    for (int i = 10; i >= 0; i--) fb[len++] = v.id[i];
    fb[len++] = v.ext ? 1'b1 : v.rtr;
    fb[len++] = v.ext;
    if (v.ext) begin
      for (int i = 17; i >= 0; i--) fb[len++] = v.eid[i];
      fb[len++] = v.rtr;
      fb[len++] = 1'b0;
      fb[len++] = 1'b0;
    end else begin
      fb[len++] = 1'b0;
    end
    for (int i = 3; i >= 0; i--) fb[len++] = v.dlc[i];
    for (int i = 0; i < nb * 8; i++) fb[len++] = v.data[63 - i];
    for (int i = 14; i >= 0; i--) fb[len++] = v.crc[i];
    fb[len++] = !v.corrupt[3];
    fb[len++] = v.ack;
    fb[len++] = !v.corrupt[4];
    for (int i = 0; i < 7; i++) fb[len++] = !(v.corrupt[5] && i == 3);
    doneCount = 0; validSeen = 0; doneOnLast = 0; stuffCount = 0;
    run = 0; prev = 1'b1;
    for (int p = 0; p < len; p++) begin
      if (p <= last + 15 && run == 5) begin
        sendBit(!prev, 0);
        stuffCount++;
        prev = !prev;
        run = 1;
      end
      sendBit(fb[p], p == len - 1);
      if (run > 0 && fb[p] == prev) run = (run == 5) ? 5 : run + 1;
      else run = 1;
      prev = fb[p];
    end
  endtask

  function automatic logic [63:0] expData(input vec_t v);
    int nb;
    logic [63:0] mask;
    nb = v.rtr ? 0 : ((v.dlc > 4'd8) ? 8 : int'(v.dlc));
    mask = (nb == 0) ? 64'h0 : (~64'h0 << (64 - 8 * nb));
    return v.data & mask;
  endfunction

  function automatic logic [5:0] expViol(input vec_t v);
    logic [5:0] e;
    e = 6'b0;
    e[0] = v.corrupt[0];
    e[1] = (v.id[10:4] == 7'h7F);
    e[2] = (v.dlc > 4'd8);
    e[3] = v.corrupt[3];
    e[4] = v.corrupt[4];
    e[5] = v.corrupt[5];
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 frameDone", 64'(frameDone), 64'h0);
    chk("R11 frameValid", 64'(frameValid), 64'h0);
    chk("R11 ids", 64'(fullId) | 64'(baseId) | 64'(extId), 64'h0);
    chk("R11 fields", dataOut | 64'(crcField) | 64'(dlc) | 64'(violations)
        | 64'({isExtended, isRemote, ackSeen}), 64'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      bit okExp;
      v = VECS[k];
      sendFrame(v);
      okExp = (expViol(v) == 6'b0);
      chk("R9 single done on last bit", 64'({doneCount[7:0], 7'b0, doneOnLast}), 64'({8'd1, 8'd1}));
      chk("R10 frameValid", 64'(validSeen), 64'(okExp));
      if (v.ext) begin
        chk("R4 fullId", 64'(fullId), 64'({v.id, v.eid}));
        chk("R4 extId", 64'(extId), 64'(v.eid));
      end else begin
        chk("R3 fullId", 64'(fullId), 64'(v.id));
        chk("R3 baseId/extId", 64'({baseId, extId}), 64'({v.id, 18'h0}));
      end
      chk("R3 format and remote flags", 64'({isExtended, isRemote}), 64'({v.ext, v.rtr}));
      chk("R3 dlc", 64'(dlc), 64'(v.dlc));
      chk("R5 dataOut", dataOut, expData(v));
      chk("R7 crcField", 64'(crcField), 64'(v.crc));
      chk("R7 ackSeen", 64'(ackSeen), 64'(!v.ack));
      chk("R8 violations", 64'(violations), 64'(expViol(v)));
      repeat (k % 3) @(negedge clk);
    end

    // R1: long dominant runs need many stuff bits and still parse
    sendFrame(VECS[1]);
    chk("R1 stuff bits inserted", 64'(stuffCount > 6), 64'h1);
    chk("R1 destuffed fields", {dataOut[63:11], baseId}, 64'h0);
    chk("R1 frame accepted", 64'({doneOnLast, validSeen}), 64'h3);

    // R2: CRC ends with five zeros, recessive delimiter must not be dropped
    sendFrame(VECS[2]);
    chk("R2 crc at boundary", 64'(crcField), 64'h7FE0);
    chk("R2 delimiter kept", 64'({violations, doneOnLast}), 64'h1);

    // R6: oversize length code clamps data to eight bytes
    sendFrame(VECS[4]);
    chk("R6 raw dlc", 64'(dlc), 64'hF);
    chk("R6 eight bytes", dataOut, 64'hFFEE_DDCC_BBAA_9988);
    chk("R6 flag", 64'(violations[2]), 64'h1);

    // R5: remote frame with non-zero length takes no data
    sendFrame(VECS[3]);
    chk("R5 remote no data", dataOut, 64'h0);
    chk("R5 remote crc alignment", 64'(crcField), 64'h2A55);

    // R8: flags clear at the next start bit
    sendFrame(VECS[6]);
    sendBit(1'b0, 0);
    chk("R8 cleared at start", 64'(violations), 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule